// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received frame should be kept or discarded by looking only at its 48-bit destination address. The receive path presents the six address bytes together with a one-cycle strobe, along with the current filter settings. One clock later the block raises a single-cycle completion pulse, and a verdict flag travels with that pulse.

A frame is accepted when any one of five tests passes. The tests are: accept everything, accept every group address, accept the all-ones broadcast address, match one of sixteen programmable exact-match entries, or hit a set bit in a 4096-bit multicast hash table. All five tests run in parallel and their results are ORed. Software fills the exact-match entries and the hash table through simple word-write ports. After reset both stores are empty, so only the promiscuous and broadcast tests can pass a frame.

Top module: `dst_addr_filter`

## Requirements
- R1: When `uni_promisc` is high at the strobe, the frame is accepted whatever its address.
- R2: When `mc_promisc` is high, a frame whose first address byte has bit 0 set (the group bit, `rx_addr[0]`) is accepted. A frame with that bit clear is not accepted by this test.
- R3: When `bcast_en` is high and all 48 address bits are one, the frame is accepted. With `bcast_en` low, the broadcast address passes only if another test passes.
- R4: There are 16 exact-match entries, each written as a lower word (`ent_wr_upper`=0) and an upper word (`ent_wr_upper`=1). An entry takes part only while bit 31 of its upper word is set, and then it matches when all 48 stored address bits equal the received address. Rewriting the upper word with bit 31 clear removes the entry.
- R5: Address byte k (k=0 is the first byte on the wire) arrives on `rx_addr[8k+7:8k]`. An entry stores bytes 0 to 3 in lower-word bits [7:0], [15:8], [23:16] and [31:24], byte 4 in upper-word bits [7:0], and byte 5 in upper-word bits [15:8].
- R6: The hash index is ({byte5, byte4} >> s) & 0xFFF, where byte5 is the most significant byte and s is 4, 3, 2 or 0 for `hash_sel` values 0, 1, 2 or 3.
- R7: The hash table is written as 128 words of 32 bits on `hash_wr_idx`/`hash_wr_data`. A frame is accepted when bit (index mod 32) of word (index / 32) is set.
- R8: `done` is high for exactly the cycle after each strobe and low otherwise. `accept` is valid during `done` and is held low whenever `done` is low.
- R9: After reset, `done` and `accept` are low, every entry is invalid and every hash bit is zero, so with all three enables low no frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: address and settings are valid |
| rx_addr | input | 48 | Destination address, byte k in bits [8k+7:8k] |
| uni_promisc | input | 1 | Accept every frame |
| mc_promisc | input | 1 | Accept every group-addressed frame |
| bcast_en | input | 1 | Accept the all-ones address |
| hash_sel | input | 2 | Hash bit-offset select |
| ent_wr_en | input | 1 | Exact-match entry word write |
| ent_wr_idx | input | 4 | Entry number |
| ent_wr_upper | input | 1 | 0 selects the lower word, 1 selects the upper word |
| ent_wr_data | input | 32 | Entry word data |
| hash_wr_en | input | 1 | Hash table word write |
| hash_wr_idx | input | 7 | Hash word number |
| hash_wr_data | input | 32 | Hash word data |
| done | output | 1 | Verdict pulse, one cycle after the strobe |
| accept | output | 1 | Frame accepted (valid with `done`) |

## Verification
Plain unicast addresses are applied first with every store empty and every enable off, then under each enable in turn. This separates the promiscuous, group and broadcast paths from one another, and a group or broadcast address that is rejected shows that no path leaks. Exact-match entries are checked with addresses that differ from a programmed entry only in the last byte, which exposes a byte-order or partial-compare error, and again after the valid bit is cleared. Group addresses with a single hash bit set are checked under every offset select, so a wrong shift lands on a different, empty bit.

// File: rtl/daf_pkg.sv
// Shared definitions for the destination address filter.
// Assumes a 48-bit address and a 12-bit hash index (4096-bit table).
package daf_pkg;
    localparam int MAC_W      = 48;
    localparam int HASH_IDX_W = 12;

    typedef logic [1:0] hsel_t;

    // Hash index from the two last address bytes; select 0..3 -> shift 4,3,2,0.
    function automatic logic [HASH_IDX_W-1:0] hash_pick(input logic [15:0] top16,
                                                        input hsel_t sel);
        logic [HASH_IDX_W-1:0] r;
        case (sel)
            2'd0:    r = HASH_IDX_W'(top16 >> 4);
            2'd1:    r = HASH_IDX_W'(top16 >> 3);
            2'd2:    r = HASH_IDX_W'(top16 >> 2);
            default: r = HASH_IDX_W'(top16);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/daf_exact_cam.sv
// Exact-match address store: ENTRIES entries, each written as a lower and an
// upper word. Upper word bit 31 is the valid bit, bits [15:0] hold bytes 4..5.
// Assumes word writes never coincide with a need to see the new value the
// same cycle (a lookup sees the contents before the write).
module daf_exact_cam #(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 32,
    parameter int MAC_W   = 48
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic                       wr_upper,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic [MAC_W-1:0]           look_addr,
    output logic                       any_hit
);
    localparam int UP_W  = MAC_W - WORD_W;
    localparam int VLD_B = WORD_W - 1;

    logic [ENTRIES-1:0] hit_vec;
    logic               unused_mid;

    assign unused_mid = ^wr_data[VLD_B-1:UP_W];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [WORD_W-1:0] lo_q;
        logic [UP_W-1:0]   up_q;
        logic              vld_q;

        // Capture the word written to this entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q  <= '0;
                up_q  <= '0;
                vld_q <= 1'b0;
            end else if (wr_en && (wr_idx == g)) begin
                if (wr_upper) begin
                    up_q  <= wr_data[UP_W-1:0];
                    vld_q <= wr_data[VLD_B];
                end else begin
                    lo_q <= wr_data;
                end
            end
        end

        // Compare this entry with the address being looked up.
        always_comb hit_vec[g] = vld_q && ({up_q, lo_q} == look_addr);

        // R4
        ent_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_upper && (wr_idx == g) && !wr_data[VLD_B]) |=> !hit_vec[g]);
    end

    // Reduce per-entry hits.
    always_comb any_hit = |hit_vec;
endmodule

// File: rtl/daf_hash_table.sv
// Multicast hash bit table, WORDS words of W bits, written a word at a time.
// Lookup is combinational on a flat bit index (word = upper bits, bit = lower).
module daf_hash_table #(
    parameter int WORDS = 128,
    parameter int W     = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [$clog2(WORDS)-1:0]          wr_idx,
    input  logic [W-1:0]                      wr_data,
    input  logic [$clog2(WORDS*W)-1:0]        look_idx,
    output logic                              hit
);
    localparam int BSEL_W = $clog2(W);
    localparam int IDX_W  = $clog2(WORDS * W);

    logic [W-1:0] tbl [WORDS];

    // Clear on reset, otherwise take word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_data;
        end
    end

    // Select the addressed bit.
    always_comb hit = tbl[look_idx[IDX_W-1:BSEL_W]][look_idx[BSEL_W-1:0]];

    // R7
    hash_clear_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data == '0) && !$isunknown(look_idx)) |=>
            ((look_idx[IDX_W-1:BSEL_W] != $past(wr_idx)) || !hit));
endmodule

// File: rtl/daf_verdict.sv
// Registers the OR of the individual test results into a one-cycle verdict.
// Assumes all test inputs are combinational results for the strobed address.
module daf_verdict (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic pass_uni,
    input  logic pass_mc,
    input  logic pass_bc,
    input  logic pass_cam,
    input  logic pass_hash,
    output logic done,
    output logic accept
);
    // Pulse done after each strobe and hold accept low between verdicts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            accept <= 1'b0;
        end else begin
            done   <= strobe;
            accept <= strobe && (pass_uni || pass_mc || pass_bc || pass_cam || pass_hash);
        end
    end

    // R8
    accept_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> done);
    // R8
    done_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> done);
    // R8
    no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !done);
endmodule

// File: rtl/dst_addr_filter.sv
// Destination address filter top. Runs the promiscuous, group, broadcast,
// exact-match and hash tests in parallel on the strobed address and reports
// a registered verdict one cycle later. Settings are sampled with the strobe.
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter int WORD_W     = 32,
    parameter int HASH_WORDS = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_valid,
    input  logic [MAC_W-1:0]              rx_addr,
    input  logic                          uni_promisc,
    input  logic                          mc_promisc,
    input  logic                          bcast_en,
    input  logic [1:0]                    hash_sel,
    input  logic                          ent_wr_en,
    input  logic [$clog2(ENTRIES)-1:0]    ent_wr_idx,
    input  logic                          ent_wr_upper,
    input  logic [WORD_W-1:0]             ent_wr_data,
    input  logic                          hash_wr_en,
    input  logic [$clog2(HASH_WORDS)-1:0] hash_wr_idx,
    input  logic [WORD_W-1:0]             hash_wr_data,
    output logic                          done,
    output logic                          accept
);
    localparam int TOP_LSB = MAC_W - 16;

    logic                  is_group, is_bcast, cam_hit, hash_hit;
    logic [HASH_IDX_W-1:0] hidx;

    // Address class decode and hash index.
    always_comb begin
        is_group = rx_addr[0];
        is_bcast = &rx_addr;
        hidx     = hash_pick(rx_addr[MAC_W-1:TOP_LSB], hash_sel);
    end

    daf_exact_cam #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .MAC_W(MAC_W)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ent_wr_en),
        .wr_idx   (ent_wr_idx),
        .wr_upper (ent_wr_upper),
        .wr_data  (ent_wr_data),
        .look_addr(rx_addr),
        .any_hit  (cam_hit)
    );

    daf_hash_table #(.WORDS(HASH_WORDS), .W(WORD_W)) u_hash (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hash_wr_en),
        .wr_idx  (hash_wr_idx),
        .wr_data (hash_wr_data),
        .look_idx(hidx),
        .hit     (hash_hit)
    );

    daf_verdict u_verdict (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (rx_valid),
        .pass_uni (uni_promisc),
        .pass_mc  (mc_promisc && is_group),
        .pass_bc  (bcast_en && is_bcast),
        .pass_cam (cam_hit),
        .pass_hash(hash_hit),
        .done     (done),
        .accept   (accept)
    );

    // R1
    promisc_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && uni_promisc) |=> accept);
    // R2
    group_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mc_promisc && rx_addr[0]) |=> accept);
    // R3
    bcast_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && bcast_en && (rx_addr == '1)) |=> accept);
endmodule

// File: tb/dst_addr_filter_test.sv
module dst_addr_filter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid;
    logic [47:0] rx_addr;
    logic        uni_promisc, mc_promisc, bcast_en;
    logic [1:0]  hash_sel;
    logic        ent_wr_en, ent_wr_upper;
    logic [3:0]  ent_wr_idx;
    logic [31:0] ent_wr_data;
    logic        hash_wr_en;
    logic [6:0]  hash_wr_idx;
    logic [31:0] hash_wr_data;
    logic        done, accept;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dst_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_addr(rx_addr),
        .uni_promisc(uni_promisc), .mc_promisc(mc_promisc), .bcast_en(bcast_en),
        .hash_sel(hash_sel), .ent_wr_en(ent_wr_en), .ent_wr_idx(ent_wr_idx),
        .ent_wr_upper(ent_wr_upper), .ent_wr_data(ent_wr_data),
        .hash_wr_en(hash_wr_en), .hash_wr_idx(hash_wr_idx),
        .hash_wr_data(hash_wr_data), .done(done), .accept(accept)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Build a 48-bit address from bytes b0 (first) .. b5.
    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    // Bench-side hash index from the requirement.
    function automatic int hidx(input logic [47:0] a, input int sel);
        int sh;
        sh = (sel == 0) ? 4 : (sel == 1) ? 3 : (sel == 2) ? 2 : 0;
        return (int'({a[47:40], a[39:32]}) >> sh) & 12'hFFF;
    endfunction

    // Strobe one address and check the verdict one cycle later.
    task automatic lookup(input logic [47:0] a, input logic exp, input string req);
        @(negedge clk);
        rx_addr  = a;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        check({req, " done"}, done, 1'b1);
        check(req, accept, exp);
    endtask

    task automatic ent_write(input int idx, input logic up, input logic [31:0] d);
        @(negedge clk);
        ent_wr_en = 1'b1; ent_wr_idx = 4'(idx); ent_wr_upper = up; ent_wr_data = d;
        @(negedge clk);
        ent_wr_en = 1'b0;
    endtask

    task automatic hash_write(input int w, input logic [31:0] d);
        @(negedge clk);
        hash_wr_en = 1'b1; hash_wr_idx = 7'(w); hash_wr_data = d;
        @(negedge clk);
        hash_wr_en = 1'b0;
    endtask

    // R9: reset state and nothing accepted with empty stores.
    task automatic t_reset;
        @(negedge clk);
        check("R9 done after reset", done, 1'b0);
        check("R9 accept after reset", accept, 1'b0);
        lookup(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 1'b0, "R9 unicast drop");
        lookup(mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'hAB, 8'hCD), 1'b0, "R9 group drop");
        lookup('1, 1'b0, "R9 broadcast drop");
    endtask

    // R1: accept-all.
    task automatic t_promisc;
        uni_promisc = 1'b1;
        lookup(mk(8'h02, 8'h99, 8'h88, 8'h77, 8'h66, 8'h55), 1'b1, "R1 unicast");
        lookup(mk(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06), 1'b1, "R1 group");
        uni_promisc = 1'b0;
    endtask

    // R2: group promiscuous.
    task automatic t_group;
        mc_promisc = 1'b1;
        lookup(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01), 1'b1, "R2 group accept");
        lookup(mk(8'h32, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01), 1'b0, "R2 unicast drop");
        mc_promisc = 1'b0;
    endtask

    // R3: broadcast.
    task automatic t_bcast;
        bcast_en = 1'b1;
        lookup('1, 1'b1, "R3 broadcast accept");
        lookup(48'hFFFF_FFFF_FFFE, 1'b0, "R3 near-broadcast drop");
        bcast_en = 1'b0;
        lookup('1, 1'b0, "R3 broadcast disabled");
    endtask

    // R4, R5: exact-match entries.
    task automatic t_exact;
        // address 02:11:22:33:44:55 -> lower 0x33221102, upper 0x8000_5544
        ent_write(5, 1'b0, 32'h3322_1102);
        ent_write(5, 1'b1, 32'h8000_5544);
        lookup(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 1'b1, "R5 byte order match");
        lookup(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56), 1'b0, "R5 last byte differs");
        lookup(mk(8'h03, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 1'b0, "R5 first byte differs");
        ent_write(15, 1'b0, 32'hDDCC_BBAA);
        ent_write(15, 1'b1, 32'h8000_FFEE);
        lookup(mk(8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 8'hFF), 1'b1, "R4 entry 15 match");
        ent_write(5, 1'b1, 32'h0000_5544);
        lookup(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 1'b0, "R4 invalidated entry");
        ent_write(15, 1'b1, 32'h0000_FFEE);
        lookup(mk(8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 8'hFF), 1'b0, "R4 entry 15 invalidated");
    endtask

    // R6, R7: hash lookup under each offset select.
    task automatic t_hash;
        logic [47:0] a;
        int          idx, oth;
        a = mk(8'h01, 8'h00, 8'h5E, 8'h10, 8'hAB, 8'hCD);
        for (int s = 0; s < 4; s++) begin
            idx = hidx(a, s);
            hash_sel = 2'(s);
            hash_write(idx >> 5, 32'h1 << (idx & 31));
            lookup(a, 1'b1, $sformatf("R6 sel %0d index hit", s));
            oth = hidx(a, (s + 1) % 4);
            if ((oth >> 5) != (idx >> 5) || (oth & 31) != (idx & 31)) begin
                hash_sel = 2'((s + 1) % 4);
                lookup(a, 1'b0, $sformatf("R6 sel %0d other offset miss", s));
            end
            hash_write(idx >> 5, ~(32'h1 << (idx & 31)) & 32'h0);
            hash_sel = 2'(s);
            lookup(a, 1'b0, $sformatf("R7 sel %0d cleared word", s));
        end
        // Neighbour bit in the same word must not hit.
        idx = hidx(a, 0);
        hash_sel = 2'd0;
        hash_write(idx >> 5, ~(32'h1 << (idx & 31)));
        lookup(a, 1'b0, "R7 other bits of word");
        hash_write(idx >> 5, 32'h0);
    endtask

    // R8: done is a single pulse.
    task automatic t_pulse;
        uni_promisc = 1'b1;
        lookup(48'h0000_0000_0002, 1'b1, "R8 verdict");
        @(negedge clk);
        check("R8 done drops", done, 1'b0);
        check("R8 accept drops", accept, 1'b0);
        uni_promisc = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; rx_valid = 1'b0; rx_addr = '0;
        uni_promisc = 1'b0; mc_promisc = 1'b0; bcast_en = 1'b0; hash_sel = 2'd0;
        ent_wr_en = 1'b0; ent_wr_idx = '0; ent_wr_upper = 1'b0; ent_wr_data = '0;
        hash_wr_en = 1'b0; hash_wr_idx = '0; hash_wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_promisc();
        t_group();
        t_bcast();
        t_exact();
        t_hash();
        t_pulse();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule